// File: doc/BRIEF.md
# Answer-to-Reset Identification Streamer

This block sends a fixed identification word out on the serial data line. A device reset pulse triggers it, so no bus command or start condition is needed. The host selects the device by pulling chip select low, raises the reset line and then lowers it. On the falling edge of that reset pulse the block takes ownership of the data line and drives the first bit. Each later falling edge of the serial clock moves the line to the next bit. After the last bit the line is released.

The block samples the serial clock, reset and select pins in the system clock domain. It assumes these pins are already synchronised to that clock. A busy input from the main bus logic blocks the stream from starting while a nonvolatile write is in progress. Deselecting the device at any point cancels the stream at once. An ownership output tells the surrounding pad logic when this block drives the data line. The identification word, its width and its bit order are parameters.

Top module: `atr_stream`

## Requirements
- R1: During synchronous reset and on the first cycle after it, `own_o` is 0 and `sda_o` is 1.
- R2: A stream starts only if `req_i` rose while `sel_n_i` was 0 and then fell while `sel_n_i` was still 0. The cycle after the clock edge that samples the fall, `own_o` is 1 and `sda_o` carries bit index 0 of the stream.
- R3: A `req_i` fall sampled while `busy_i` is 1 starts no stream, and `own_o` stays 0.
- R4: While streaming, each sampled falling edge of `scl_i` advances the stream by exactly one bit. A rising edge, or no edge at all, leaves `sda_o` unchanged.
- R5: Stream bit index k is `PATTERN[k]` when `ORDER` is least-significant first (the default). It is `PATTERN[WIDTH-1-k]` when `ORDER` is most-significant first.
- R6: The `WIDTH`-th `scl_i` falling edge after the start releases the line: `own_o` becomes 0, and whenever `own_o` is 0, `sda_o` is 1.
- R7: If `sel_n_i` is sampled high during a stream, `own_o` is 0 the next cycle. The stream does not resume when the device is selected again.
- R8: A `req_i` pulse that began while `sel_n_i` was 1 starts no stream, even if `sel_n_i` is 0 when `req_i` falls.
- R9: Activity on `req_i` while a stream runs is ignored, and the stream continues with the same bit sequence.
- R10: `scl_i` edges while no stream runs have no effect: `own_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock, already synchronised |
| req_i | input | 1 | Answer-to-reset request pin, active high pulse |
| sel_n_i | input | 1 | Chip select, active low |
| busy_i | input | 1 | Nonvolatile write in progress |
| sda_o | output | 1 | Serial data value (1 when not owned) |
| own_o | output | 1 | This block drives the data line |

## Verification
A wrong bit index appears as an `sda_o` value that differs from the model's word bit one cycle after the `scl_i` fall that moved the index. An off-by-one in the end count shows as `own_o` being released one serial-clock period early or late. A stuck arming or ownership flag shows as `own_o` rising after a blocked or unarmed pulse, or staying high after deselect. In each case the mismatch appears within one system clock of the causing edge, because the bench compares both orders against the model on every cycle.

// File: rtl/atr_pkg.sv
// Shared types for the answer-to-reset streamer.
package atr_pkg;
    // Which end of the identification word leaves the block first.
    typedef enum logic {
        ATR_LSB_FIRST = 1'b0,
        ATR_MSB_FIRST = 1'b1
    } atr_order_e;
endpackage

// File: rtl/atr_edge.sv
// Single-edge detector on a pre-synchronised pin.
// Assumes: sig_i is already in the clk domain. The history flop resets to 0.
module atr_edge #(
    parameter bit RISING = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic edge_o
);
    logic sig_q;

    // Keep last cycle's pin value.
    always_ff @(posedge clk) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig_i;
    end

    generate
        if (RISING) begin : g_rise
            assign edge_o = sig_i & ~sig_q;
        end else begin : g_fall
            assign edge_o = sig_q & ~sig_i;
        end
    endgenerate
endmodule

// File: rtl/atr_seq.sv
// Stream sequencer: arms on a selected request rise, starts on its fall,
// counts serial-clock falls, and ends on the last bit or on deselect.
// Assumes: edge strobes come from atr_edge and last one cycle.
module atr_seq #(
    parameter int WIDTH = 32,
    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_n_i,
    input  logic             busy_i,
    input  logic             req_rise_i,
    input  logic             req_fall_i,
    input  logic             scl_fall_i,
    output logic             active_o,
    output logic [IDX_W-1:0] idx_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(WIDTH - 1);

    logic armed_q;
    logic active_q;
    logic [IDX_W-1:0] idx_q;

    // Arm, start, advance and finish the stream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q  <= 1'b0;
            active_q <= 1'b0;
            idx_q    <= '0;
        end else if (sel_n_i) begin
            armed_q  <= 1'b0;
            active_q <= 1'b0;
        end else if (active_q) begin
            if (scl_fall_i) begin
                if (idx_q == LAST) active_q <= 1'b0;
                else               idx_q    <= idx_q + 1'b1;
            end
        end else begin
            if (req_rise_i) armed_q <= 1'b1;
            if (req_fall_i) begin
                armed_q <= 1'b0;
                if (armed_q && !busy_i) begin
                    active_q <= 1'b1;
                    idx_q    <= '0;
                end
            end
        end
    end

    assign active_o = active_q;
    assign idx_o    = idx_q;
endmodule

// File: rtl/atr_bitsel.sv
// Picks the current stream bit from the fixed word in the chosen order.
// Assumes: idx_i < WIDTH.
module atr_bitsel
    import atr_pkg::*;
#(
    parameter int                WIDTH   = 32,
    parameter logic [WIDTH-1:0]  PATTERN = '0,
    parameter atr_order_e        ORDER   = ATR_LSB_FIRST,
    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic             bit_o
);
    generate
        if (ORDER == ATR_LSB_FIRST) begin : g_lsb
            assign bit_o = PATTERN[idx_i];
        end else begin : g_msb
            logic [IDX_W-1:0] ridx;
            assign ridx  = IDX_W'(WIDTH - 1) - idx_i;
            assign bit_o = PATTERN[ridx];
        end
    endgenerate
endmodule

// File: rtl/atr_stream.sv
// Answer-to-reset streamer top. Sends PATTERN on sda_o, one bit per serial-clock fall.
// Assumes: all pins are synchronised to clk. Pad logic drives the line only while own_o is 1.
module atr_stream
    import atr_pkg::*;
#(
    parameter int               WIDTH   = 32,
    parameter logic [WIDTH-1:0] PATTERN = 32'hA5C3_1E96,
    parameter atr_order_e       ORDER   = ATR_LSB_FIRST
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic req_i,
    input  logic sel_n_i,
    input  logic busy_i,
    output logic sda_o,
    output logic own_o
);
    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;

    logic req_rise, req_fall, scl_fall;
    logic active;
    logic [IDX_W-1:0] idx;
    logic cur_bit;

    atr_edge #(.RISING(1'b1)) u_req_rise (.clk(clk), .rst_n(rst_n), .sig_i(req_i), .edge_o(req_rise));
    atr_edge #(.RISING(1'b0)) u_req_fall (.clk(clk), .rst_n(rst_n), .sig_i(req_i), .edge_o(req_fall));
    atr_edge #(.RISING(1'b0)) u_scl_fall (.clk(clk), .rst_n(rst_n), .sig_i(scl_i), .edge_o(scl_fall));

    atr_seq #(.WIDTH(WIDTH)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_n_i    (sel_n_i),
        .busy_i     (busy_i),
        .req_rise_i (req_rise),
        .req_fall_i (req_fall),
        .scl_fall_i (scl_fall),
        .active_o   (active),
        .idx_o      (idx)
    );

    atr_bitsel #(.WIDTH(WIDTH), .PATTERN(PATTERN), .ORDER(ORDER)) u_bitsel (
        .idx_i (idx),
        .bit_o (cur_bit)
    );

    // Released line reads high; owned line carries the current bit.
    assign sda_o = active ? cur_bit : 1'b1;
    assign own_o = active;
endmodule

// File: rtl/atr_stream_chk.sv
// Port-level checker for atr_stream, attached by bind.
module atr_stream_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic req_i,
    input logic sel_n_i,
    input logic busy_i,
    input logic sda_o,
    input logic own_o
);
    // Reset leaves the line released.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!own_o && sda_o));

    // Ownership begins only after a selected, non-busy request fall.
    assert_start_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(own_o) |-> ($past(!req_i) && $past(!sel_n_i) && $past(!busy_i)));

    // Busy blocks a start.
    assert_busy_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !own_o) |=> !own_o);

    // Without a serial-clock fall the bit holds.
    assert_bit_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (own_o && !sel_n_i && !$fell(scl_i)) |=> $stable(sda_o));

    // Released line reads high.
    assert_idle_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !own_o |-> sda_o);

    // Deselect cancels at once.
    assert_desel_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n_i |=> !own_o);

    // Idle serial-clock activity never claims the line.
    assert_idle_scl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!own_o && !$fell(req_i)) |=> !own_o);
endmodule

bind atr_stream atr_stream_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl_i),
    .req_i   (req_i),
    .sel_n_i (sel_n_i),
    .busy_i  (busy_i),
    .sda_o   (sda_o),
    .own_o   (own_o)
);

// File: tb/tb_atr_stream.sv
module tb_atr_stream;
    import atr_pkg::*;

    localparam logic [31:0] PAT = 32'hA5C3_1E96;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b0, req = 1'b0, sel_n = 1'b1, busy = 1'b0;
    logic sda_l, own_l, sda_m, own_m;

    always #2 clk = ~clk;  // 250 MHz

    atr_stream #(.WIDTH(32), .PATTERN(PAT), .ORDER(ATR_LSB_FIRST)) dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .req_i(req), .sel_n_i(sel_n),
        .busy_i(busy), .sda_o(sda_l), .own_o(own_l));

    atr_stream #(.WIDTH(32), .PATTERN(PAT), .ORDER(ATR_MSB_FIRST)) dut_msb (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .req_i(req), .sel_n_i(sel_n),
        .busy_i(busy), .sda_o(sda_m), .own_o(own_m));

    int checks = 0, fails = 0, cycles = 0;
    string tag = "R1";
    bit started = 0;

    // Behavioural reference model.
    int m_act = 0, m_arm = 0, m_idx = 0, p_scl = 0, p_req = 0;
    always @(posedge clk) begin
        started <= 1;
        if (!rst_n) begin
            m_act = 0; m_arm = 0; m_idx = 0; p_scl = 0; p_req = 0;
        end else begin
            if (sel_n) begin
                m_arm = 0; m_act = 0;
            end else if (m_act != 0) begin
                if (p_scl == 1 && scl == 0) begin
                    if (m_idx == 31) m_act = 0;
                    else m_idx = m_idx + 1;
                end
            end else begin
                if (p_req == 0 && req == 1) m_arm = 1;
                if (p_req == 1 && req == 0) begin
                    if (m_arm != 0 && !busy) begin m_act = 1; m_idx = 0; end
                    m_arm = 0;
                end
            end
            p_scl = int'(scl); p_req = int'(req);
        end
    end

    task automatic check(input bit ok, input string r, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", r, act, exp, cycles);
        end
    endtask

    // Compare both instances against the model on every cycle.
    always @(negedge clk) begin
        cycles++;
        if (started) begin
            check(own_l == (m_act != 0), tag, own_l, m_act);
            check(sda_l == ((m_act != 0) ? PAT[m_idx] : 1'b1), tag, sda_l,
                  (m_act != 0) ? PAT[m_idx] : 1);
            check(own_m == (m_act != 0), tag, own_m, m_act);
            check(sda_m == ((m_act != 0) ? PAT[31-m_idx] : 1'b1), tag, sda_m,
                  (m_act != 0) ? PAT[31-m_idx] : 1);
        end
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_req();
        req = 1'b1; tick(2); req = 1'b0; tick(2);
    endtask

    task automatic scl_cycle();
        scl = 1'b1; tick(2); scl = 1'b0; tick(2);
    endtask

    // Run a full stream and gather the bits seen on both instances.
    task automatic full_stream(output logic [31:0] got_l, output logic [31:0] got_m);
        pulse_req();
        for (int k = 0; k < 32; k++) begin
            got_l[k] = sda_l; got_m[k] = sda_m;
            scl_cycle();
        end
    endtask

    logic [31:0] gl, gm;

    initial begin
        tick(3);
        tag = "R1";
        check(own_l == 0 && sda_l == 1, "R1 reset idle", own_l, 0);
        rst_n = 1'b1;
        tick(1);
        check(own_l == 0 && sda_l == 1, "R1 first cycle", own_l, 0);

        tag = "R10"; sel_n = 1'b0;
        for (int k = 0; k < 5; k++) scl_cycle();
        check(own_l == 0, "R10 idle scl", own_l, 0);

        tag = "R2";
        req = 1'b1; tick(2); req = 1'b0; tick(1);
        check(own_l == 1, "R2 start own", own_l, 1);
        check(sda_l == PAT[0], "R2 first bit", sda_l, PAT[0]);
        tag = "R4";
        scl = 1'b1; tick(2);
        check(sda_l == PAT[0], "R4 rise holds", sda_l, PAT[0]);
        scl = 1'b0; tick(1);
        check(sda_l == PAT[1], "R4 fall advances", sda_l, PAT[1]);
        sel_n = 1'b1; tick(2); sel_n = 1'b0; tick(1);

        tag = "R5";
        full_stream(gl, gm);
        check(gl == PAT, "R5 lsb order", int'(gl), int'(PAT));
        check(gm == {<<{PAT}}, "R5 msb order", int'(gm), int'({<<{PAT}}));
        tag = "R6";
        check(own_l == 0 && sda_l == 1, "R6 released", own_l, 0);

        tag = "R9";
        pulse_req();
        for (int k = 0; k < 32; k++) begin
            gl[k] = sda_l;
            if (k == 10) begin req = 1'b1; tick(1); req = 1'b0; tick(1); end
            scl_cycle();
        end
        check(gl == PAT, "R9 req ignored", int'(gl), int'(PAT));

        tag = "R7";
        pulse_req();
        for (int k = 0; k < 10; k++) scl_cycle();
        sel_n = 1'b1; tick(1);
        check(own_l == 0, "R7 abort", own_l, 0);
        tick(2); sel_n = 1'b0;
        for (int k = 0; k < 3; k++) scl_cycle();
        check(own_l == 0, "R7 no resume", own_l, 0);

        tag = "R3";
        busy = 1'b1; pulse_req();
        check(own_l == 0, "R3 busy blocks", own_l, 0);
        busy = 1'b0; tick(2);

        tag = "R8";
        sel_n = 1'b1; req = 1'b1; tick(2); sel_n = 1'b0; tick(2); req = 1'b0; tick(2);
        check(own_l == 0, "R8 unarmed", own_l, 0);

        tag = "R6";
        full_stream(gl, gm);
        check(gl == PAT && own_l == 0, "R6 second stream", int'(gl), int'(PAT));

        tick(4);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule